// File: doc/BRIEF.md
# Eight-bit ALU with status-flag update

The block takes one operation at a time over a valid/ready input channel, computes an 8-bit result with a combinational arithmetic and logic core, and merges the new condition bits into the incoming flag byte. The block does not hold the flag byte. The user supplies the current flags with each operation, and the block returns the updated byte together with the result. Each operation rewrites only its own subset of flags. Every other flag bit is copied through unchanged.

The operations cover addition and subtraction, with and without carry or borrow, and compare, which computes flags only. They also cover the bitwise operations, complement and negate, increment and decrement, the shifts and rotates, and nibble exchange. A single output register stage holds the result, the new flag byte and a write-enable. This stage forms the output channel.

Back-pressure rules: `in_ready` is high whenever the output stage is empty or is being emptied in the same cycle. An operation is taken on a rising edge with `in_valid` and `in_ready` both high. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `alu8_core`

## Requirements
- R1: An operation accepted on a clock edge appears with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, all outputs hold. `in_ready` equals `!out_valid || out_ready`.
- R2: The flag byte is ordered from bit 7 down to bit 0 as I, T, H, S, V, N, Z, C. Bits 7 and 6 (I, T) are always copied from `in_flags`.
- R3: Op 0 (add) computes a+b, and op 1 (add with carry) computes a+b+`in_cin`. Both set the following flags: C is the carry out of bit 7, H is the carry out of bit 3, V is the signed overflow, N is result bit 7, and Z is set when the result is zero.
- R4: Op 2 (subtract) computes a-b, and op 3 (subtract with borrow) computes a-b-`in_cin`. C is the borrow out of bit 7, H is the borrow into bit 4, V is the signed overflow, and N is result bit 7. For op 2, Z is set when the result is zero. For op 3, Z is set only when the result is zero and `in_flags` Z was already set.
- R5: Op 4 (compare) and op 5 (compare with borrow) produce the same flags as op 2 and op 3 respectively, with `out_we` low. Every other defined op (0 to 18) drives `out_we` high.
- R6: Ops 6, 7 and 8 (AND, OR, XOR of a and b) clear V and update N and Z. C and H are unchanged.
- R7: Op 9 (complement) gives 0xFF-a, sets C, clears V, and leaves H unchanged. Op 10 (negate) gives 0x00-a with C = (a != 0), V = (result == 0x80), and H = borrow into bit 4.
- R8: Op 11 (a+1) sets V only when a was 0x7F. Op 12 (a-1) sets V only when a was 0x80. Both update N and Z and leave C and H unchanged.
- R9: Op 13 (shift left, bit 0 gets 0) puts bit 7 into C. Op 14 (shift right, bit 7 gets 0) puts bit 0 into C. Op 17 (arithmetic shift right, bit 7 kept) puts bit 0 into C. For all shifts and rotates, V = N xor C, and H is unchanged.
- R10: Op 15 (rotate left) moves bit 7 to C and `in_cin` to bit 0. Op 16 (rotate right) moves bit 0 to C and `in_cin` to bit 7.
- R11: Op 18 exchanges bits 7..4 with bits 3..0 and returns `in_flags` unchanged.
- R12: For every op from 0 to 17, the output S equals output N xor output V.
- R13: For op codes 19 to 31, the result equals a, the flag byte equals `in_flags`, and `out_we` is low.
- R14: While `rst` is high, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | DW | First operand (destination value) |
| in_b | input | DW | Second operand (register or constant) |
| in_cin | input | 1 | Incoming carry for carry and rotate forms |
| in_flags | input | 8 | Current flag byte |
| out_valid | output | 1 | Result held in output stage |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | DW | Computed value |
| out_we | output | 1 | Result should be written back |
| out_flags | output | 8 | Updated flag byte |

## Verification
The hardest case to reach is the chained zero test. A borrow-form subtract or compare must produce a zero difference while the incoming Z is clear, and a result register must stall at the same moment. The stimulus forces this with directed vectors that use equal operands and a cleared Z. A random phase then draws a fresh flag byte for every operation and holds `out_ready` low on about a quarter of the cycles. Each result is compared against a behavioural model as it leaves the block.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADC  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SBC  = 5'd3;
  localparam logic [4:0] OP_CMP  = 5'd4;
  localparam logic [4:0] OP_CPC  = 5'd5;
  localparam logic [4:0] OP_AND  = 5'd6;
  localparam logic [4:0] OP_OR   = 5'd7;
  localparam logic [4:0] OP_XOR  = 5'd8;
  localparam logic [4:0] OP_COM  = 5'd9;
  localparam logic [4:0] OP_NEG  = 5'd10;
  localparam logic [4:0] OP_INC  = 5'd11;
  localparam logic [4:0] OP_DEC  = 5'd12;
  localparam logic [4:0] OP_LSL  = 5'd13;
  localparam logic [4:0] OP_LSR  = 5'd14;
  localparam logic [4:0] OP_ROL  = 5'd15;
  localparam logic [4:0] OP_ROR  = 5'd16;
  localparam logic [4:0] OP_ASR  = 5'd17;
  localparam logic [4:0] OP_SWAP = 5'd18;

  // flag byte bit positions
  localparam int FB_C = 0;
  localparam int FB_Z = 1;
  localparam int FB_N = 2;
  localparam int FB_V = 3;
  localparam int FB_S = 4;
  localparam int FB_H = 5;

  // update masks over bits 5..0 (H S V N Z C)
  localparam logic [5:0] UPD_ARITH = 6'b111111;
  localparam logic [5:0] UPD_LOGIC = 6'b011110;
  localparam logic [5:0] UPD_SHIFT = 6'b011111;
  localparam logic [5:0] UPD_NONE  = 6'b000000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          h_out,
  output logic          v_out
);
  localparam int MSB = DW - 1;
  localparam int HB  = 3;

  logic [DW:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
    else     ext = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
    sum   = ext[MSB:0];
    c_out = ext[DW];
    if (sub) begin
      h_out = (~x[HB] & y[HB]) | (y[HB] & sum[HB]) | (sum[HB] & ~x[HB]);
      v_out = (x[MSB] & ~y[MSB] & ~sum[MSB]) | (~x[MSB] & y[MSB] & sum[MSB]);
    end else begin
      h_out = (x[HB] & y[HB]) | (y[HB] & ~sum[HB]) | (~sum[HB] & x[HB]);
      v_out = (x[MSB] & y[MSB] & ~sum[MSB]) | (~x[MSB] & ~y[MSB] & sum[MSB]);
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          v_out
);
  localparam int MSB = DW - 1;
  localparam int NIB = DW / 2;

  logic is_shift;

  always_comb begin
    res      = a;
    c_out    = 1'b0;
    is_shift = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  begin res = ~a; c_out = 1'b1; end
      OP_LSL:  begin res = {a[MSB-1:0], 1'b0}; c_out = a[MSB]; is_shift = 1'b1; end
      OP_LSR:  begin res = {1'b0, a[MSB:1]};   c_out = a[0];   is_shift = 1'b1; end
      OP_ROL:  begin res = {a[MSB-1:0], cin};  c_out = a[MSB]; is_shift = 1'b1; end
      OP_ROR:  begin res = {cin, a[MSB:1]};    c_out = a[0];   is_shift = 1'b1; end
      OP_ASR:  begin res = {a[MSB], a[MSB:1]}; c_out = a[0];   is_shift = 1'b1; end
      OP_SWAP: res = {a[NIB-1:0], a[MSB:NIB]};
      default: res = a;
    endcase
    v_out = is_shift & (res[MSB] ^ c_out);
  end
endmodule

// File: rtl/alu8_flagmerge.sv
module alu8_flagmerge
  import alu8_pkg::*;
(
  input  logic [7:0] old_flags,
  input  logic [5:0] upd,
  input  logic       h_new,
  input  logic       v_new,
  input  logic       n_new,
  input  logic       z_new,
  input  logic       c_new,
  output logic [7:0] new_flags
);
  logic [7:0] cand;
  logic [7:0] sel;

  assign cand = {old_flags[7:6], h_new, n_new ^ v_new, v_new, n_new, z_new, c_new};
  assign sel  = {2'b00, upd};

  for (genvar i = 0; i < 8; i++) begin : g_bit
    assign new_flags[i] = sel[i] ? cand[i] : old_flags[i];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [4:0]    in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic          in_cin,
  input  logic [7:0]    in_flags,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_we,
  output logic [7:0]    out_flags
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] as_x, as_y, as_sum, bo_res, res;
  logic          as_cin, as_sub, as_c, as_h, as_v;
  logic          bo_c, bo_v;
  logic          use_as, chain_z, we;
  logic [5:0]    upd;
  logic          n_new, z_new, c_new, v_new;
  logic [7:0]    flags_nx;

  always_comb begin
    as_x    = in_a;
    as_y    = in_b;
    as_cin  = 1'b0;
    as_sub  = 1'b0;
    use_as  = 1'b0;
    chain_z = 1'b0;
    we      = 1'b1;
    upd     = UPD_NONE;
    case (in_op)
      OP_ADD: begin use_as = 1'b1; upd = UPD_ARITH; end
      OP_ADC: begin use_as = 1'b1; upd = UPD_ARITH; as_cin = in_cin; end
      OP_SUB: begin use_as = 1'b1; upd = UPD_ARITH; as_sub = 1'b1; end
      OP_SBC: begin
        use_as = 1'b1; upd = UPD_ARITH; as_sub = 1'b1;
        as_cin = in_cin; chain_z = 1'b1;
      end
      OP_CMP: begin use_as = 1'b1; upd = UPD_ARITH; as_sub = 1'b1; we = 1'b0; end
      OP_CPC: begin
        use_as = 1'b1; upd = UPD_ARITH; as_sub = 1'b1;
        as_cin = in_cin; chain_z = 1'b1; we = 1'b0;
      end
      OP_NEG: begin
        use_as = 1'b1; upd = UPD_ARITH; as_sub = 1'b1;
        as_x = '0; as_y = in_a;
      end
      OP_INC: begin use_as = 1'b1; upd = UPD_LOGIC; as_y = DW'(1); end
      OP_DEC: begin use_as = 1'b1; upd = UPD_LOGIC; as_sub = 1'b1; as_y = DW'(1); end
      OP_AND, OP_OR, OP_XOR: upd = UPD_LOGIC;
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: upd = UPD_SHIFT;
      OP_SWAP: upd = UPD_NONE;
      default: begin upd = UPD_NONE; we = 1'b0; end
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op(in_op), .a(in_a), .b(in_b), .cin(in_cin),
    .res(bo_res), .c_out(bo_c), .v_out(bo_v)
  );

  always_comb begin
    res   = use_as ? as_sum : bo_res;
    c_new = use_as ? as_c : bo_c;
    v_new = use_as ? as_v : bo_v;
    n_new = res[MSB];
    z_new = (res == '0) & (~chain_z | in_flags[FB_Z]);
  end

  alu8_flagmerge u_merge (
    .old_flags(in_flags), .upd(upd),
    .h_new(as_h), .v_new(v_new), .n_new(n_new), .z_new(z_new), .c_new(c_new),
    .new_flags(flags_nx)
  );

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_we     <= 1'b0;
      out_flags  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res;
        out_we     <= we;
        out_flags  <= flags_nx;
      end
    end
  end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [4:0]    in_op,
  input logic [7:0]    in_flags,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result,
  input logic          out_we,
  input logic [7:0]    out_flags
);
  logic take;
  assign take = in_valid & in_ready;

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_we));

  a_r1_accept: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  a_r2_it_kept: assert property (@(posedge clk) disable iff (rst)
    take |=> out_flags[7:6] == $past(in_flags[7:6]));

  a_r4_zero_chain: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_SBC || in_op == OP_CPC) && !in_flags[FB_Z] |=> !out_flags[FB_Z]);

  a_r5_cmp_nowrite: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_CMP || in_op == OP_CPC) |=> !out_we);

  a_r6_ch_kept: assert property (@(posedge clk) disable iff (rst)
    take && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR || in_op == OP_INC || in_op == OP_DEC)
    |=> out_flags[FB_C] == $past(in_flags[FB_C]) && out_flags[FB_H] == $past(in_flags[FB_H]));

  a_r11_swap_flags: assert property (@(posedge clk) disable iff (rst)
    take && in_op == OP_SWAP |=> out_flags == $past(in_flags));

  a_r12_sign: assert property (@(posedge clk) disable iff (rst)
    take && in_op <= OP_ASR |=> out_flags[FB_S] == (out_flags[FB_N] ^ out_flags[FB_V]));

  a_r13_undef: assert property (@(posedge clk) disable iff (rst)
    take && in_op > OP_SWAP |=> !out_we && out_flags == $past(in_flags));

  a_r14_reset: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind alu8_core alu8_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_we(out_we), .out_flags(out_flags)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0;
  logic       in_cin = 1'b0;
  logic [7:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic       out_we;
  logic [7:0] out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [16:0] exp_q[$];
  int          op_q[$];

  always #2 clk = ~clk;

  alu8_core #(.DW(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_we(out_we), .out_flags(out_flags)
  );

  function automatic string tag(int op);
    case (op)
      0, 1:      return "R3";
      2, 3:      return "R4";
      4, 5:      return "R5";
      6, 7, 8:   return "R6";
      9, 10:     return "R7";
      11, 12:    return "R8";
      13, 14, 17: return "R9";
      15, 16:    return "R10";
      18:        return "R11";
      default:   return "R13";
    endcase
  endfunction

  // behavioural reference: {we, result, flags}
  function automatic logic [16:0] model(int op, int a, int b, int c, logic [7:0] f);
    int r, d, kind;
    logic [7:0] res, nf;
    logic we, cc, hh, vv, zz, chain;
    nf = f; we = 1'b1; res = 8'(a); cc = 0; hh = 0; vv = 0; chain = 0; kind = 3;
    case (op)
      0, 1: begin
        d = (op == 1) ? c : 0; r = a + b + d; res = 8'(r);
        cc = r > 255; hh = ((a & 15) + (b & 15) + d) > 15;
        vv = (a[7] == b[7]) && (res[7] != a[7]); kind = 0;
      end
      2, 3, 4, 5: begin
        d = (op == 3 || op == 5) ? c : 0; r = a - b - d; res = 8'(r);
        cc = r < 0; hh = ((a & 15) - (b & 15) - d) < 0;
        vv = (a[7] != b[7]) && (res[7] != a[7]); kind = 0;
        we = op < 4; chain = (op == 3 || op == 5);
      end
      6:  begin res = 8'(a & b); kind = 1; end
      7:  begin res = 8'(a | b); kind = 1; end
      8:  begin res = 8'(a ^ b); kind = 1; end
      9:  begin res = 8'(255 - a); cc = 1; kind = 2; end
      10: begin res = 8'(0 - a); cc = a != 0; hh = (a & 15) != 0; vv = res == 8'h80; kind = 0; end
      11: begin res = 8'(a + 1); vv = a == 127; kind = 1; end
      12: begin res = 8'(a - 1); vv = a == 128; kind = 1; end
      13: begin res = 8'(a * 2); cc = a[7]; kind = 2; end
      14: begin res = 8'(a / 2); cc = a[0]; kind = 2; end
      15: begin res = 8'(a * 2 + c); cc = a[7]; kind = 2; end
      16: begin res = 8'(c * 128 + a / 2); cc = a[0]; kind = 2; end
      17: begin res = 8'((a & 128) + a / 2); cc = a[0]; kind = 2; end
      18: begin res = 8'((a % 16) * 16 + a / 16); kind = 3; end
      default: begin res = 8'(a); we = 1'b0; kind = 3; end
    endcase
    if (op >= 13 && op <= 17) vv = res[7] ^ cc;
    zz = (res == 8'h00) && (!chain || f[1]);
    if (kind != 3) begin
      nf[2] = res[7]; nf[1] = zz; nf[3] = vv; nf[4] = res[7] ^ vv;
      if (kind == 0 || kind == 2) nf[0] = cc;
      if (kind == 0) nf[5] = hh;
    end
    return {we, res, nf};
  endfunction

  task automatic observe();
    logic [16:0] e;
    int op;
    checks++;
    if (out_valid !== (exp_q.size() != 0)) begin // R1 occupancy
      errors++;
      $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, exp_q.size() != 0);
    end
    if (out_valid && out_ready && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      op = op_q.pop_front();
      checks++;
      if ({out_we, out_result} !== e[16:8]) begin
        errors++;
        $display("FAIL %s op %0d we/result actual %h expected %h", tag(op), op, {out_we, out_result}, e[16:8]);
      end
      checks++;
      if (out_flags !== e[7:0]) begin
        errors++;
        $display("FAIL %s op %0d flags actual %b expected %b", tag(op), op, out_flags, e[7:0]);
      end
      checks++;
      if (out_flags[7:6] !== e[7:6]) begin
        errors++;
        $display("FAIL R2 op %0d I/T actual %b expected %b", op, out_flags[7:6], e[7:6]);
      end
      if (op <= 17) begin
        checks++;
        if (out_flags[4] !== (out_flags[3] ^ out_flags[2])) begin
          errors++;
          $display("FAIL R12 op %0d S actual %b expected %b", op, out_flags[4], out_flags[3] ^ out_flags[2]);
        end
      end
    end
  endtask

  task automatic send(int op, int a, int b, int c, logic [7:0] f);
    bit taken = 0;
    in_op = 5'(op); in_a = 8'(a); in_b = 8'(b); in_cin = c[0]; in_flags = f;
    in_valid = 1'b1;
    while (!taken) begin
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      observe();
      if (in_ready) begin
        exp_q.push_back(model(op, a, b, c, f));
        op_q.push_back(op);
        taken = 1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 100) begin
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      observe();
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin // R14
      errors++;
      $display("FAIL R14 reset valid/ready actual %b%b expected 01", out_valid, in_ready);
    end
    rst = 1'b0;
    @(negedge clk);

    send(0, 8'h80, 8'h80, 0, 8'h00);   // R3 carry+overflow+zero
    send(0, 8'h0F, 8'h01, 0, 8'hC0);   // R3 half carry, I/T kept
    send(1, 8'h7F, 8'h00, 1, 8'h00);   // R3 carry in gives overflow
    send(2, 8'h10, 8'h01, 0, 8'h00);   // R4 half borrow
    send(3, 8'h05, 8'h05, 0, 8'h00);   // R4 zero chain blocked
    send(3, 8'h05, 8'h05, 0, 8'h02);   // R4 zero chain kept
    send(3, 8'h00, 8'h00, 1, 8'h02);   // R4 borrow through
    send(4, 8'h33, 8'h33, 0, 8'h00);   // R5 compare no write
    send(5, 8'h40, 8'h3F, 1, 8'h00);   // R5 compare with borrow, Z cleared in
    send(6, 8'hF0, 8'h0F, 0, 8'h2F);   // R6 AND to zero, C/H kept
    send(8, 8'hAA, 8'h55, 0, 8'h08);   // R6 XOR clears V
    send(9, 8'h00, 8'h00, 0, 8'h00);   // R7 complement
    send(10, 8'h80, 8'h00, 0, 8'h00);  // R7 negate 0x80
    send(10, 8'h00, 8'h00, 0, 8'h01);  // R7 negate zero
    send(11, 8'h7F, 8'h00, 0, 8'h21);  // R8 inc overflow
    send(12, 8'h80, 8'h00, 0, 8'h21);  // R8 dec overflow
    send(13, 8'h81, 8'h00, 0, 8'h00);  // R9 shift left
    send(14, 8'h01, 8'h00, 0, 8'h00);  // R9 shift right to zero
    send(17, 8'h81, 8'h00, 0, 8'h00);  // R9 arithmetic shift
    send(15, 8'h80, 8'h00, 1, 8'h00);  // R10 rotate left
    send(16, 8'h01, 8'h00, 1, 8'h00);  // R10 rotate right
    send(18, 8'h3C, 8'h00, 1, 8'hA5);  // R11 nibble exchange
    send(25, 8'h99, 8'h11, 1, 8'h5A);  // R13 undefined code
    send(31, 8'h00, 8'h00, 0, 8'hFF);  // R13 undefined code

    for (int i = 0; i < 2500; i++) begin
      int op;
      op = ($urandom_range(0, 9) == 0) ? $urandom_range(19, 31) : $urandom_range(0, 18);
      send(op, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1),
           8'($urandom_range(0, 255)));
    end
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule